// File: doc/BRIEF.md
# Page-Mode Controller for Asynchronous Multiplexed-Address DRAM

This block sits between a simple host request port and an asynchronous DRAM whose row and column addresses share one set of pins. The host presents a word read or write with a row, a column and write data. The controller turns it into a sequence of active-low strobes. The row strobe latches the row address when it falls. The column strobe latches the column address on the same pins when it falls. Write enable and output enable steer the direction of the data pins. The data bus is modelled as separate in and out vectors plus a drive enable.

After an access the row stays open, with the row strobe held low, so a later access to the same row needs only a column cycle. An access to a different row first raises the row strobe for a precharge period and then opens the new row. A close input lets the host give up the open row while no request is pending. The three timings (precharge, row-to-column delay and column-to-data) are parameters counted in clock cycles.

Top module: `dpm_ctrl`

## Requirements
- R1: In reset and directly after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted while no row is open is followed by T_RCD cycles with `dram_ras_n`=0, `dram_cas_n`=1 and the row on `dram_addr`, then one column-setup cycle with `dram_cas_n`=1 and the column on `dram_addr`, then T_CAS cycles with `dram_cas_n`=0 and the column held on `dram_addr`.
- R3: A request to the open row (page hit) starts directly with the column-setup cycle. `dram_ras_n` stays 0 throughout and no new row address is presented.
- R4: A request to a row other than the open one first drives `dram_ras_n`=1 for exactly T_RP cycles, then follows the R2 sequence for the new row.
- R5: `dram_we_n` and `dram_oe_n` are never 0 in the same cycle. For a write, `dram_we_n` is 0 from the column-setup cycle to the last column cycle, so it falls before `dram_cas_n`. For a read, `dram_oe_n` is 0 exactly during the T_CAS column cycles.
- R6: `dram_dq_oe` is 1 exactly during the setup and column cycles of a write, and `dram_dq_out` then carries the write data.
- R7: For a read, `dram_dq_in` is sampled at the end of the last column cycle. In the following cycle `rsp_valid` is 1 for one cycle and `rsp_rdata` carries that value. `rsp_valid` is 0 in every other cycle.
- R8: `req_ready` is 1 only when no access is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both 1. While idle with a row open, `dram_ras_n` stays 0 and all other strobes stay 1.
- R9: `close_row`, sampled while idle with a row open and `req_valid`=0, drives `dram_ras_n`=1 for T_RP cycles, after which no row is open and the next access follows R2 with no precharge. `close_row` while no row is open has no effect: the strobes stay at 1 and `req_ready` stays 1.
- R10: `dram_cas_n` is 0 only while `dram_ras_n` is 0, and `dram_addr` does not change while `dram_cas_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ADDR_W | Row address of the request |
| req_col | input | ADDR_W | Column address of the request |
| req_wdata | input | DATA_W | Write data |
| close_row | input | 1 | Give up the open row while idle |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | ADDR_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
Every cycle, the assertions check the electrical safety rules: write and output enable never overlap, the column strobe only falls inside an open row, the column address holds while the column strobe is low, write enable leads the column strobe, and the precharge and row-to-column spacing are never shortened. Only the bench scenarios can show that the right sequence was chosen for each request: that a hit skips the row cycle, that a row change inserts precharge, that closing the row turns the next access into a plain open, and that the data read back matches what was written earlier at that row and column. The bench reference model predicts every pin in every cycle and checks data through a behavioural memory that latches addresses on the strobe edges.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_CSET,
        ST_CAS
    } dpm_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } dpm_strobe_t;

    function automatic dpm_strobe_t strobe_of(dpm_state_e st, logic row_open, logic wr);
        dpm_strobe_t s;
        s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        case (st)
            ST_IDLE: s.ras_n = !row_open;
            ST_PRE:  s.ras_n = 1'b1;
            ST_ACT:  s.ras_n = 1'b0;
            ST_CSET: begin
                s.ras_n = 1'b0;
                s.we_n  = !wr;
            end
            ST_CAS: begin
                s.ras_n = 1'b0;
                s.cas_n = 1'b0;
                s.we_n  = !wr;
                s.oe_n  = wr;
            end
            default: s.ras_n = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dpm_timer.sv
module dpm_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dpm_row_track.sv
module dpm_row_track #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [ADDR_W-1:0] set_row,
    input  logic [ADDR_W-1:0] cmp_row,
    output logic              open,
    output logic              hit
);
    logic [ADDR_W-1:0] row_q;
    logic              open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (clr) begin
            open_q <= 1'b0;
        end else if (set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end
    end

    assign open = open_q;
    assign hit  = open_q && (row_q == cmp_row);
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              close_row,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int T_MAX = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                           : ((T_CAS > T_RP) ? T_CAS : T_RP);
    localparam int CNT_W = $clog2(T_MAX) + 1;
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] CAS_LD = CNT_W'(T_CAS - 1);

    dpm_state_e        st_q, st_d;
    logic              wr_q, pend_q, rsp_q;
    logic [ADDR_W-1:0] row_q, col_q;
    logic [DATA_W-1:0] wd_q, rd_q;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              row_set, row_clr, row_open, row_hit;
    logic              accept;
    dpm_strobe_t       stb;

    assign accept = req_valid && (st_q == ST_IDLE);

    dpm_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    dpm_row_track #(.ADDR_W(ADDR_W)) u_rows (
        .clk(clk), .rst(rst), .set(row_set), .clr(row_clr),
        .set_row((st_q == ST_IDLE) ? req_row : row_q),
        .cmp_row(req_row), .open(row_open), .hit(row_hit)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        row_set  = 1'b0;
        row_clr  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (row_hit) begin
                        st_d = ST_CSET;
                    end else if (row_open) begin
                        st_d = ST_PRE; tmr_load = 1'b1; tmr_val = RP_LD; row_clr = 1'b1;
                    end else begin
                        st_d = ST_ACT; tmr_load = 1'b1; tmr_val = RCD_LD; row_set = 1'b1;
                    end
                end else if (close_row && row_open) begin
                    st_d = ST_PRE; tmr_load = 1'b1; tmr_val = RP_LD; row_clr = 1'b1;
                end
            end
            ST_PRE: begin
                if (tmr_done) begin
                    if (pend_q) begin
                        st_d = ST_ACT; tmr_load = 1'b1; tmr_val = RCD_LD; row_set = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_ACT:  if (tmr_done) st_d = ST_CSET;
            ST_CSET: begin
                st_d = ST_CAS; tmr_load = 1'b1; tmr_val = CAS_LD;
            end
            ST_CAS:  if (tmr_done) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wr_q   <= 1'b0;
            pend_q <= 1'b0;
            rsp_q  <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            st_q  <= st_d;
            rsp_q <= 1'b0;
            if (st_q == ST_IDLE) pend_q <= req_valid;
            if (accept) begin
                wr_q  <= req_write;
                row_q <= req_row;
                col_q <= req_col;
                wd_q  <= req_wdata;
            end
            if (st_q == ST_CAS && tmr_done && !wr_q) begin
                rd_q  <= dram_dq_in;
                rsp_q <= 1'b1;
            end
        end
    end

    assign stb         = strobe_of(st_q, row_open, wr_q);
    assign dram_ras_n  = stb.ras_n;
    assign dram_cas_n  = stb.cas_n;
    assign dram_we_n   = stb.we_n;
    assign dram_oe_n   = stb.oe_n;
    assign dram_addr   = (st_q == ST_CSET || st_q == ST_CAS) ? col_q : row_q;
    assign dram_dq_oe  = wr_q && (st_q == ST_CSET || st_q == ST_CAS);
    assign dram_dq_out = wd_q;
    assign req_ready   = (st_q == ST_IDLE);
    assign rsp_valid   = rsp_q;
    assign rsp_rdata   = rd_q;

    // Spacing monitors for the strobe timing checks
    localparam int MON_MAX = T_RP + T_RCD + 2;
    localparam int MON_W   = $clog2(MON_MAX + 1) + 1;
    logic [MON_W-1:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= MON_W'(T_RP);
            lo_cnt <= '0;
        end else begin
            if (dram_ras_n) begin
                lo_cnt <= '0;
                if (hi_cnt < MON_W'(MON_MAX)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt < MON_W'(MON_MAX)) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!dram_we_n && !dram_oe_n)); // R5
    AST_WE_LEADS_CAS: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R5
    AST_PRECHARGE_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (hi_cnt >= MON_W'(T_RP))); // R4
    AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_cas_n) |-> (lo_cnt >= MON_W'(T_RCD + 1))); // R2
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n); // R10
    AST_COL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_addr)); // R10
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe)); // R8
    AST_DQ_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> !dram_we_n); // R6
endmodule

// File: tb/test_dpm_ctrl.sv
`timescale 1ns/1ps
module test_dpm_ctrl;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, close_row = 1'b0;
    logic [AW-1:0] req_row = '0, req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] rsp_rdata, dram_dq_out;
    logic [DW-1:0] dram_dq_in = '0;
    logic [AW-1:0] dram_addr;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dpm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) i_dpm_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .close_row(close_row), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    typedef struct {
        bit ras, cas, we, oe, dqoe, chka, lastrd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string tag;
    } exp_t;

    exp_t q[$];
    bit m_open = 0;
    logic [AW-1:0] m_row = '0;
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] mem [int];
    bit rsp_due = 0;
    logic [DW-1:0] rsp_exp = '0;
    logic [AW-1:0] d_row = '0;
    bit prev_ras = 1;

    task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    function automatic exp_t mk(bit ras, bit cas, bit we, bit oe, bit dqoe, bit chka,
                                bit lastrd, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        exp_t e;
        e.ras = ras; e.cas = cas; e.we = we; e.oe = oe; e.dqoe = dqoe; e.chka = chka;
        e.lastrd = lastrd; e.addr = a; e.data = d; e.tag = tag;
        return e;
    endfunction

    function automatic void plan(bit w, logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
        string tg;
        int key;
        logic [DW-1:0] v;
        key = int'({r, c});
        if (m_open && m_row == r) begin
            tg = "R3";
        end else begin
            if (m_open)
                for (int i = 0; i < T_RP; i++) q.push_back(mk(1,1,1,1,0,0,0,'0,'0,"R4"));
            for (int i = 0; i < T_RCD; i++) q.push_back(mk(0,1,1,1,0,1,0,r,'0,"R2"));
            m_open = 1;
            m_row  = r;
            tg = "R2";
        end
        if (w) begin
            shadow[key] = d;
            v = d;
        end else begin
            v = shadow.exists(key) ? shadow[key] : '0;
        end
        q.push_back(mk(0,1,!w,1,w,1,0,c,v,tg));
        for (int i = 0; i < T_CAS; i++)
            q.push_back(mk(0,0,!w,w,w,1,(!w && i == T_CAS-1),c,v,tg));
    endfunction

    // Reference model, compared every cycle
    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            bit has_e;
            has_e = (q.size() != 0);
            if (has_e) e = q.pop_front();
            else e = mk(!m_open,1,1,1,0,0,0,'0,'0,"R8");
            cmp(e.tag, "ras_n", 32'(dram_ras_n), 32'(e.ras));
            cmp(e.tag, "cas_n", 32'(dram_cas_n), 32'(e.cas));
            cmp((e.we == 0) ? "R5" : e.tag, "we_n", 32'(dram_we_n), 32'(e.we));
            cmp((e.oe == 0) ? "R5" : e.tag, "oe_n", 32'(dram_oe_n), 32'(e.oe));
            cmp("R6", "dq_oe", 32'(dram_dq_oe), 32'(e.dqoe));
            cmp("R8", "req_ready", 32'(req_ready), 32'(!has_e));
            cmp("R5", "we_oe_overlap", 32'(!dram_we_n && !dram_oe_n), 32'd0);
            cmp("R10", "cas_without_ras", 32'(!dram_cas_n && dram_ras_n), 32'd0);
            if (e.chka) cmp(e.tag, "addr", 32'(dram_addr), 32'(e.addr));
            if (e.dqoe) cmp("R6", "dq_out", 32'(dram_dq_out), 32'(e.data));
            if (rsp_due) begin
                cmp("R7", "rsp_valid", 32'(rsp_valid), 32'd1);
                cmp("R7", "rsp_rdata", 32'(rsp_rdata), 32'(rsp_exp));
            end else begin
                cmp("R7", "rsp_valid", 32'(rsp_valid), 32'd0);
            end
            rsp_due = has_e && e.lastrd;
            rsp_exp = e.data;
            if (!has_e) begin
                if (req_valid) plan(req_write, req_row, req_col, req_wdata);
                else if (close_row && m_open) begin
                    for (int i = 0; i < T_RP; i++) q.push_back(mk(1,1,1,1,0,0,0,'0,'0,"R9"));
                    m_open = 0;
                end
            end
        end
        // Behavioural DRAM: row latched on RAS fall, column on CAS low
        if (!dram_ras_n && prev_ras) d_row = dram_addr;
        prev_ras = dram_ras_n;
        if (!dram_cas_n && !dram_we_n) mem[int'({d_row, dram_addr})] = dram_dq_out;
        if (!dram_cas_n && !dram_oe_n)
            dram_dq_in = mem.exists(int'({d_row, dram_addr})) ? mem[int'({d_row, dram_addr})] : '0;
    end

    task automatic issue(bit w, logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = w; req_row = r; req_col = c; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_close();
        @(posedge clk); #1;
        close_row = 1;
        @(posedge clk); #1;
        close_row = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cmp("R1", "ras_n", 32'(dram_ras_n), 32'd1);
        cmp("R1", "cas_n", 32'(dram_cas_n), 32'd1);
        cmp("R1", "we_n", 32'(dram_we_n), 32'd1);
        cmp("R1", "oe_n", 32'(dram_oe_n), 32'd1);
        cmp("R1", "dq_oe", 32'(dram_dq_oe), 32'd0);
        cmp("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        cmp("R1", "req_ready", 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        rst = 0;
        issue(1, 9'd5, 9'd3, 8'hA5);      // R2 open from closed
        wait_idle();
        issue(0, 9'd5, 9'd3, 8'h00);      // R3 hit, R7 data
        issue(1, 9'd5, 9'd10, 8'h3C);     // R3 hit write
        issue(0, 9'd5, 9'd10, 8'h00);
        issue(1, 9'd9, 9'd1, 8'h77);      // R4 row change
        issue(0, 9'd5, 9'd3, 8'h00);      // R4 back, R7
        wait_idle();
        repeat (5) @(posedge clk);        // R8 row held open
        pulse_close();                    // R9 close
        wait_idle();
        pulse_close();                    // R9 ignored while closed
        wait_idle();
        issue(0, 9'd9, 9'd1, 8'h00);      // R9 plain open, no precharge
        wait_idle();
        for (int i = 0; i < 16; i++)
            issue(i[0], 9'((i % 3) * 7), 9'(i * 5 + 1), 8'(i * 17 + 1));
        issue(0, 9'd14, 9'd51, 8'h00);
        issue(0, 9'd0, 9'd1, 8'h00);
        wait_idle();
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule